// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Registered Result

This block performs the integer operations that a 32-bit base integer core needs for its register-register and register-immediate instructions. These are addition, subtraction, signed and unsigned less-than tests, bitwise XOR, OR and AND, and left, logical-right and arithmetic-right shifts. The caller supplies two operands and the instruction's 3-bit function field, the alternate-operation bit (instruction bit 30), and a flag that marks the immediate form. For the immediate form, operand B already holds the sign-extended 12-bit immediate. A further select routes operand B straight to the result, so that an upper-immediate value can pass through the same datapath.

The arithmetic is computed combinationally and captured in a result register on the clock edge at which an input-valid strobe is high. An output-valid flag rises in the same cycle as the new result. The less-than operations reuse the subtract path, so a single adder serves four operations.

Top module: `int_alu_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `out_valid` is 0 and `result` is zero.
- R2: With function code 000 in the register form, `alt_op`=0 gives A+B and `alt_op`=1 gives A-B. Both wrap modulo 2^32, and no overflow indication is produced.
- R3: In the immediate form (`imm_form`=1), function code 000 always adds, whatever the value of `alt_op`.
- R4: Function code 010 returns 1 when A is less than B as two's-complement signed numbers, and 0 otherwise.
- R5: Function code 011 returns 1 when A is less than B as unsigned numbers, and 0 otherwise.
- R6: Function codes 100, 110 and 111 return the bitwise XOR, OR and AND of A and B.
- R7: Function code 001 shifts A left by B[4:0] and fills the vacated bits with zeros. B[31:5] has no effect.
- R8: Function code 101 shifts A right by B[4:0]. `alt_op`=0 fills the vacated bits with zeros, and `alt_op`=1 fills them with A[31]. This holds in both forms.
- R9: When `upper_pass`=1, the result is B unchanged, whatever the function code, `alt_op` or `imm_form`.
- R10: A result computed from the inputs sampled at an edge with `in_valid`=1 appears on `result` after that edge, and `out_valid` is 1 in that cycle. After an edge with `in_valid`=0, `out_valid` is 0 and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| funct_code | input | 3 | Instruction function field |
| alt_op | input | 1 | Instruction bit 30: subtract / arithmetic shift |
| imm_form | input | 1 | Operand B is a sign-extended immediate |
| upper_pass | input | 1 | Route operand B to the result |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B or immediate |
| out_valid | output | 1 | Result register holds a fresh value |
| result | output | 32 | Registered result |

## Verification
Two functions can fall in the same cycle. The first case is the pass-through select together with a function code and alternate bit that would otherwise subtract or shift. The bench drives both at once and expects B on the output. The second case is back-to-back strobes, where the register loads a new result in the same cycle as the previous one is presented. The bench issues operations on consecutive edges and separated by idle gaps. A queued scoreboard checks every result in order, and during each idle cycle it checks that the output holds its previous value with `out_valid` low.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_SLL,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_SRL,
        OP_SRA,
        OP_OR,
        OP_AND,
        OP_PASS
    } alu_op_e;

    localparam logic [2:0] F3_ADDSUB = 3'b000;
    localparam logic [2:0] F3_SLL    = 3'b001;
    localparam logic [2:0] F3_SLT    = 3'b010;
    localparam logic [2:0] F3_SLTU   = 3'b011;
    localparam logic [2:0] F3_XOR    = 3'b100;
    localparam logic [2:0] F3_SHR    = 3'b101;
    localparam logic [2:0] F3_OR     = 3'b110;
    localparam logic [2:0] F3_AND    = 3'b111;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [2:0] funct_code,
    input  logic       alt_op,
    input  logic       imm_form,
    input  logic       upper_pass,
    output alu_op_e    op,
    output logic       sub_en
);

    always_comb begin
        op = OP_ADD;
        if (upper_pass) begin
            op = OP_PASS;
        end else begin
            unique case (funct_code)
                F3_ADDSUB: op = (alt_op && !imm_form) ? OP_SUB : OP_ADD;
                F3_SLL:    op = OP_SLL;
                F3_SLT:    op = OP_SLT;
                F3_SLTU:   op = OP_SLTU;
                F3_XOR:    op = OP_XOR;
                F3_SHR:    op = alt_op ? OP_SRA : OP_SRL;
                F3_OR:     op = OP_OR;
                F3_AND:    op = OP_AND;
                default:   op = OP_ADD;
            endcase
        end
        sub_en = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         lt_signed,
    output logic         lt_unsigned
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub_en ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
        sum   = wide[W-1:0];
        // On subtract, a carry out means no borrow: a >= b unsigned.
        lt_unsigned = ~wide[W];
        // Different signs decide directly; equal signs use the difference sign.
        lt_signed = (a[W-1] ^ b[W-1]) ? a[W-1] : wide[W-1];
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W = 32,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    data,
    input  logic [SH_W-1:0] amount,
    input  logic            to_left,
    input  logic            arith,
    output logic [W-1:0]    shifted
);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stage_in;
    logic [W-1:0] stg [0:SH_W];
    logic         fill;

    // Left shifts reuse the right-shift network on bit-reversed data.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = data[W-1-i];
        assign rev_out[i] = stg[SH_W][W-1-i];
    end

    assign stage_in = to_left ? rev_in : data;
    assign fill     = arith & ~to_left & data[W-1];
    assign stg[0]   = stage_in;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stg[s+1] = amount[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
    end

    assign shifted = to_left ? rev_out : stg[SH_W];

endmodule

// File: rtl/int_alu_unit.sv
module int_alu_unit
    import alu_pkg::*;
#(
    parameter int W = 32,
    localparam int SH_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [2:0]   funct_code,
    input  logic         alt_op,
    input  logic         imm_form,
    input  logic         upper_pass,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         out_valid,
    output logic [W-1:0] result
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } out_state_t;

    alu_op_e      op;
    logic         sub_en;
    logic [W-1:0] sum;
    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] shifted;
    logic [W-1:0] comb_res;
    out_state_t   st_d;
    out_state_t   st_q;

    alu_decode u_decode (
        .funct_code (funct_code),
        .alt_op     (alt_op),
        .imm_form   (imm_form),
        .upper_pass (upper_pass),
        .op         (op),
        .sub_en     (sub_en)
    );

    alu_addsub #(.W(W)) u_addsub (
        .a           (opnd_a),
        .b           (opnd_b),
        .sub_en      (sub_en),
        .sum         (sum),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    alu_shifter #(.W(W)) u_shift (
        .data    (opnd_a),
        .amount  (opnd_b[SH_W-1:0]),
        .to_left (op == OP_SLL),
        .arith   (op == OP_SRA),
        .shifted (shifted)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:   comb_res = sum;
            OP_SLT:           comb_res = {{(W-1){1'b0}}, lt_s};
            OP_SLTU:          comb_res = {{(W-1){1'b0}}, lt_u};
            OP_XOR:           comb_res = opnd_a ^ opnd_b;
            OP_OR:            comb_res = opnd_a | opnd_b;
            OP_AND:           comb_res = opnd_a & opnd_b;
            OP_SLL, OP_SRL,
            OP_SRA:           comb_res = shifted;
            OP_PASS:          comb_res = opnd_b;
            default:          comb_res = '0;
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = comb_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    // R10: a strobe produces a valid result on the following cycle
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: without a strobe the output is idle and holds
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R9: pass-through returns operand B unchanged
    a_r9_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && upper_pass) |=> (result == $past(opnd_b)));

    // R2: register-form add wraps modulo 2^W
    a_r2_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !upper_pass && funct_code == F3_ADDSUB && !alt_op)
        |=> (result == $past(opnd_a) + $past(opnd_b)));

    // R4: signed less-than yields only 0 or 1
    a_r4_slt_binary: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !upper_pass && funct_code == F3_SLT)
        |=> (result[W-1:1] == '0));

    // R5: unsigned less-than yields only 0 or 1
    a_r5_sltu_binary: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !upper_pass && funct_code == F3_SLTU)
        |=> (result[W-1:1] == '0));

    // R3: immediate-form code 000 adds even with the alternate bit set
    a_r3_imm_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !upper_pass && imm_form && funct_code == F3_ADDSUB)
        |=> (result == $past(opnd_a) + $past(opnd_b)));

endmodule

// File: tb/tb_int_alu_unit.sv
module tb_int_alu_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  funct_code = '0;
    logic        alt_op = 1'b0;
    logic        imm_form = 1'b0;
    logic        upper_pass = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit have_last = 1'b0;
    logic [31:0] last_res = '0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    int_alu_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .funct_code (funct_code),
        .alt_op     (alt_op),
        .imm_form   (imm_form),
        .upper_pass (upper_pass),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .out_valid  (out_valid),
        .result     (result)
    );

    function automatic logic [31:0] model(input logic [2:0] f3, input logic alt,
                                          input logic imm, input logic pass,
                                          input logic [31:0] a, input logic [31:0] b);
        logic signed [31:0] sa;
        logic signed [31:0] sb_v;
        logic [4:0] sh;
        sa = a;
        sb_v = b;
        sh = b[4:0];
        if (pass) return b;
        case (f3)
            3'b000: return (alt && !imm) ? a - b : a + b;
            3'b001: return a << sh;
            3'b010: return (sa < sb_v) ? 32'd1 : 32'd0;
            3'b011: return (a < b) ? 32'd1 : 32'd0;
            3'b100: return a ^ b;
            3'b101: return alt ? 32'(sa >>> sh) : a >> sh;
            3'b110: return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input string tag, input logic [2:0] f3, input logic alt,
                         input logic imm, input logic pass,
                         input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        funct_code = f3;
        alt_op = alt;
        imm_form = imm;
        upper_pass = pass;
        opnd_a = a;
        opnd_b = b;
        e.val = model(f3, alt, imm, pass, a, b);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opnd_a = 32'hDEAD_BEEF;
            opnd_b = 32'h1234_5678;
        end
    endtask

    // Monitor: samples mid-cycle, pops the scoreboard on each valid result
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #5;
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check("R10 unexpected valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.tag, result, e.val);
                end
                last_res = result;
                have_last = 1'b1;
            end else if (have_last) begin
                check("R10 hold", result, last_res);
            end
        end
    end

    // Watchdog
    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset result", result, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #5;
        check("R1 after release valid", {31'd0, out_valid}, 32'd0);
        check("R1 after release result", result, 32'd0);

        // back-to-back group
        issue("R2 add wrap", 3'b000, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd1);
        issue("R2 sub wrap", 3'b000, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1);
        issue("R2 add", 3'b000, 1'b0, 1'b0, 1'b0, 32'h1234_0000, 32'h0000_5678);
        issue("R3 imm ignores alt", 3'b000, 1'b1, 1'b1, 1'b0, 32'd10, 32'hFFFF_FFFD);
        idle(2);
        issue("R4 slt neg<pos", 3'b010, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd1);
        issue("R4 slt pos<neg", 3'b010, 1'b0, 1'b0, 1'b0, 32'd1, 32'hFFFF_FFFF);
        issue("R4 slt equal", 3'b010, 1'b0, 1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000);
        issue("R5 sltu small<big", 3'b011, 1'b0, 1'b0, 1'b0, 32'd1, 32'hFFFF_FFFF);
        issue("R5 sltu big<small", 3'b011, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'd1);
        idle(1);
        issue("R6 xor", 3'b100, 1'b0, 1'b0, 1'b0, 32'hF0F0_A5A5, 32'h0FF0_FFFF);
        issue("R6 or", 3'b110, 1'b0, 1'b0, 1'b0, 32'hF000_0001, 32'h0000_0F00);
        issue("R6 and", 3'b111, 1'b0, 1'b1, 1'b0, 32'hF0F0_A5A5, 32'h0FF0_FFFF);
        idle(1);
        issue("R7 sll upper b ignored", 3'b001, 1'b0, 1'b0, 1'b0, 32'h8000_0003, 32'hFFFF_FFE1);
        issue("R7 sll by 31", 3'b001, 1'b0, 1'b0, 1'b0, 32'd1, 32'd31);
        issue("R8 srl zero fill", 3'b101, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 32'd4);
        issue("R8 sra sign fill", 3'b101, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 32'd4);
        issue("R8 sra imm form", 3'b101, 1'b1, 1'b1, 1'b0, 32'hF000_00F0, 32'h0000_0404);
        issue("R8 sra positive", 3'b101, 1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'd31);
        idle(1);
        issue("R9 pass over sub", 3'b000, 1'b1, 1'b0, 1'b1, 32'h1111_1111, 32'hABCD_E000);
        issue("R9 pass over sra", 3'b101, 1'b1, 1'b1, 1'b1, 32'h8000_0000, 32'h0000_1000);
        idle(3);
        issue("R10 single", 3'b000, 1'b0, 1'b0, 1'b0, 32'd7, 32'd8);
        idle(3);

        check("R10 scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule